// File: doc/BRIEF.md
# Multi-plane packet spraying scheduler

This block sits in the transmit path of a network interface whose port is split into four independent planes, each reaching a separate fabric. For every outgoing packet it decides which plane carries it. A congestion-control engine writes an allowed-rate value for each pair of destination and plane into a small register array. When a send request arrives with a destination index, the block reads that destination's row of rates. Planes whose rate is below a programmable threshold drop out, and so do planes whose host link is down. Among the planes that remain, the block grants the one with the shallowest local transmit queue.

Equal queue depths are resolved round-robin, starting after the plane granted last. The plane granted in one cycle has its depth counted one higher in the next cycle, so back-to-back packets do not all land on one queue before its depth input catches up. When no plane qualifies, the request receives a stall. The requester holds it until a plane becomes eligible, so no packet is dropped. Link loss is handled entirely in hardware: clearing a link-up bit removes that plane from the very next decision.

Top module: `plane_spray_sched`

## Requirements
- R1: After reset no grant or stall is shown while no request is present, every stored rate holds its maximum value (all ones), and the first tied decision goes to plane 0.
- R2: A rate write stores `rate_wr_data` for the pair (`rate_wr_dest`, `rate_wr_plane`); requests for that destination use it from the next cycle on.
- R3: A plane is eligible for a destination only when its stored rate is greater than or equal to `rate_threshold`; a lower rate excludes it.
- R4: A plane whose `link_up` bit is 0 is never granted, taking effect in the same cycle the bit drops.
- R5: Among eligible planes the grant goes to the one with the smallest effective queue depth; plane p's depth is `qdepth[8p+7:8p]`.
- R6: Among eligible planes tied at the smallest depth, the grant goes to the first one found scanning upward (wrapping) from the plane after the last granted plane.
- R7: The plane granted in a cycle has its effective depth taken as its input depth plus one in the following cycle only.
- R8: A request with no eligible plane gets `stall`=1 and no grant; a held request is granted in the first cycle a plane is eligible.
- R9: In a cycle with `rate_wr_en`=1 the write takes priority: any request in that cycle is stalled and not granted.
- R10: The grant or stall answers a request in the same cycle; `grant_valid` and `stall` are never both 1 and neither is 1 without `req_valid`.
- R11: A rate write to one destination does not change the eligibility of any other destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Send request present |
| req_dest | input | 4 | Destination index of the request |
| rate_wr_en | input | 1 | Rate context write strobe |
| rate_wr_dest | input | 4 | Destination of the rate write |
| rate_wr_plane | input | 2 | Plane of the rate write |
| rate_wr_data | input | 16 | Allowed-rate value to store |
| rate_threshold | input | 16 | Minimum rate for eligibility |
| link_up | input | 4 | Per-plane host link status, 1 = up |
| qdepth | input | 32 | Per-plane local queue depth, 8 bits per plane, plane 0 in the low byte |
| grant_valid | output | 1 | Request granted this cycle |
| grant_plane | output | 2 | Plane chosen for the granted request |
| stall | output | 1 | Request present but not granted this cycle |

## Verification
The grant, chosen plane and stall depend combinationally on the current request, link status, depths and stored state, so they are due in the same cycle as the stimulus. Everything the block stores is due one edge later: a written rate, the round-robin position, and the one-cycle depth increment. The bench drives each input set one nanosecond after a rising edge and samples the outputs at the following falling edge. A check of a stored effect is therefore made in the cycle after the one that caused it. The vector table and the directed tests are ordered with care, because the round-robin position and the depth increment carry over from each vector to the next.

// File: rtl/plane_spray_pkg.sv
package plane_spray_pkg;

  localparam int DEF_PLANES  = 4;
  localparam int DEF_DESTS   = 16;
  localparam int DEF_RATE_W  = 16;
  localparam int DEF_DEPTH_W = 8;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_GRANT = 2'd1,
    OUT_STALL = 2'd2
  } spray_out_e;

endpackage

// File: rtl/rate_ctx_array.sv
module rate_ctx_array #(
  parameter int NUM_DEST   = 16,
  parameter int NUM_PLANES = 4,
  parameter int RATE_W     = 16,
  localparam int DEST_W    = $clog2(NUM_DEST),
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DEST_W-1:0]            wr_dest,
  input  logic [PLANE_W-1:0]           wr_plane,
  input  logic [RATE_W-1:0]            wr_data,
  input  logic [DEST_W-1:0]            rd_dest,
  output logic [NUM_PLANES*RATE_W-1:0] rd_rates
);

  logic [RATE_W-1:0] ctx_q [NUM_DEST][NUM_PLANES];

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
      logic entry_en;
      assign entry_en = wr_en && (wr_dest == DEST_W'(d)) && (wr_plane == PLANE_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctx_q[d][p] <= '1;
        end else if (entry_en) begin
          ctx_q[d][p] <= wr_data;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_read
    assign rd_rates[p*RATE_W +: RATE_W] = ctx_q[rd_dest][p];
  end

endmodule

// File: rtl/plane_elig_filter.sv
module plane_elig_filter #(
  parameter int NUM_PLANES = 4,
  parameter int RATE_W     = 16
) (
  input  logic [NUM_PLANES*RATE_W-1:0] rates,
  input  logic [RATE_W-1:0]            threshold,
  input  logic [NUM_PLANES-1:0]        link_up,
  output logic [NUM_PLANES-1:0]        eligible
);

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_elig
    logic rate_ok;
    assign rate_ok     = rates[p*RATE_W +: RATE_W] >= threshold;
    assign eligible[p] = rate_ok && link_up[p];
  end

endmodule

// File: rtl/plane_depth_select.sv
module plane_depth_select #(
  parameter int NUM_PLANES = 4,
  parameter int DEPTH_W    = 8,
  localparam int PLANE_W   = $clog2(NUM_PLANES),
  localparam int EFF_W     = DEPTH_W + 1
) (
  input  logic [NUM_PLANES-1:0]         eligible,
  input  logic [NUM_PLANES*DEPTH_W-1:0] depths,
  input  logic [NUM_PLANES-1:0]         bump,
  input  logic [PLANE_W-1:0]            last_plane,
  output logic                          found,
  output logic [PLANE_W-1:0]            sel_plane
);

  logic [EFF_W-1:0] eff [NUM_PLANES];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_eff
    assign eff[p] = EFF_W'(depths[p*DEPTH_W +: DEPTH_W]) + EFF_W'(bump[p]);
  end

  always_comb begin
    logic [EFF_W-1:0] best_d;
    found     = 1'b0;
    sel_plane = '0;
    best_d    = '1;
    for (int i = 0; i < NUM_PLANES; i++) begin
      int unsigned idx;
      idx = (int'(last_plane) + 1 + i) % NUM_PLANES;
      if (eligible[idx] && (!found || (eff[idx] < best_d))) begin
        found     = 1'b1;
        sel_plane = PLANE_W'(idx);
        best_d    = eff[idx];
      end
    end
  end

endmodule

// File: rtl/plane_spray_sched.sv
module plane_spray_sched
  import plane_spray_pkg::*;
#(
  parameter int NUM_PLANES = DEF_PLANES,
  parameter int NUM_DEST   = DEF_DESTS,
  parameter int RATE_W     = DEF_RATE_W,
  parameter int DEPTH_W    = DEF_DEPTH_W,
  localparam int DEST_W    = $clog2(NUM_DEST),
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [DEST_W-1:0]             req_dest,
  input  logic                          rate_wr_en,
  input  logic [DEST_W-1:0]             rate_wr_dest,
  input  logic [PLANE_W-1:0]            rate_wr_plane,
  input  logic [RATE_W-1:0]             rate_wr_data,
  input  logic [RATE_W-1:0]             rate_threshold,
  input  logic [NUM_PLANES-1:0]         link_up,
  input  logic [NUM_PLANES*DEPTH_W-1:0] qdepth,
  output logic                          grant_valid,
  output logic [PLANE_W-1:0]            grant_plane,
  output logic                          stall
);

  logic [NUM_PLANES*RATE_W-1:0] row_rates;
  logic [NUM_PLANES-1:0]        eligible;
  logic                         found;
  logic [PLANE_W-1:0]           sel_plane;

  logic [PLANE_W-1:0]    last_q, last_d;
  logic [NUM_PLANES-1:0] bump_q, bump_d;
  logic                  last_en;
  spray_out_e            outcome;

  rate_ctx_array #(
    .NUM_DEST   (NUM_DEST),
    .NUM_PLANES (NUM_PLANES),
    .RATE_W     (RATE_W)
  ) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (rate_wr_en),
    .wr_dest  (rate_wr_dest),
    .wr_plane (rate_wr_plane),
    .wr_data  (rate_wr_data),
    .rd_dest  (req_dest),
    .rd_rates (row_rates)
  );

  plane_elig_filter #(
    .NUM_PLANES (NUM_PLANES),
    .RATE_W     (RATE_W)
  ) u_filt (
    .rates     (row_rates),
    .threshold (rate_threshold),
    .link_up   (link_up),
    .eligible  (eligible)
  );

  plane_depth_select #(
    .NUM_PLANES (NUM_PLANES),
    .DEPTH_W    (DEPTH_W)
  ) u_sel (
    .eligible   (eligible),
    .depths     (qdepth),
    .bump       (bump_q),
    .last_plane (last_q),
    .found      (found),
    .sel_plane  (sel_plane)
  );

  always_comb begin
    if (!req_valid) begin
      outcome = OUT_IDLE;
    end else if (!rate_wr_en && found) begin
      outcome = OUT_GRANT;
    end else begin
      outcome = OUT_STALL;
    end
  end

  assign grant_valid = (outcome == OUT_GRANT);
  assign stall       = (outcome == OUT_STALL);
  assign grant_plane = sel_plane;

  always_comb begin
    last_en = grant_valid;
    last_d  = sel_plane;
    bump_d  = '0;
    if (grant_valid) begin
      bump_d[sel_plane] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= PLANE_W'(NUM_PLANES - 1);
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bump_q <= '0;
    end else begin
      bump_q <= bump_d;
    end
  end

endmodule

// File: rtl/plane_spray_sched_chk.sv
module plane_spray_sched_chk #(
  parameter int NUM_PLANES = 4,
  parameter int DEST_W     = 4,
  parameter int PLANE_W    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  rate_wr_en,
  input logic [NUM_PLANES-1:0] link_up,
  input logic                  grant_valid,
  input logic [PLANE_W-1:0]    grant_plane,
  input logic                  stall
);

  AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && stall)); // R10

  AST_OUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid || stall) |-> req_valid); // R10

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (grant_valid || stall)); // R8

  AST_GRANT_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> link_up[grant_plane]); // R4

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr_en && req_valid) |-> stall); // R9

  AST_NO_LINK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (link_up == '0)) |-> stall); // R8

endmodule

bind plane_spray_sched plane_spray_sched_chk #(
  .NUM_PLANES (NUM_PLANES),
  .DEST_W     (DEST_W),
  .PLANE_W    (PLANE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .rate_wr_en  (rate_wr_en),
  .link_up     (link_up),
  .grant_valid (grant_valid),
  .grant_plane (grant_plane),
  .stall       (stall)
);

// File: tb/plane_spray_sched_tb.sv
`timescale 1ns/1ps
module plane_spray_sched_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_dest;
  logic        rate_wr_en;
  logic [3:0]  rate_wr_dest;
  logic [1:0]  rate_wr_plane;
  logic [15:0] rate_wr_data;
  logic [15:0] rate_threshold;
  logic [3:0]  link_up;
  logic [31:0] qdepth;
  logic        grant_valid;
  logic [1:0]  grant_plane;
  logic        stall;

  int n_checks = 0;
  int n_errors = 0;

  plane_spray_sched u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_dest       (req_dest),
    .rate_wr_en     (rate_wr_en),
    .rate_wr_dest   (rate_wr_dest),
    .rate_wr_plane  (rate_wr_plane),
    .rate_wr_data   (rate_wr_data),
    .rate_threshold (rate_threshold),
    .link_up        (link_up),
    .qdepth         (qdepth),
    .grant_valid    (grant_valid),
    .grant_plane    (grant_plane),
    .stall          (stall)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        req;
    logic [3:0]  dest;
    logic [3:0]  link;
    logic [31:0] q;
    logic [15:0] thr;
    logic        exp_g;
    logic [1:0]  exp_p;
    logic        exp_s;
  } vec_t;

  // q packs {p3,p2,p1,p0}; state carries from each vector to the next.
  localparam vec_t VECS [8] = '{
    '{1'b1, 4'd0, 4'hF, 32'h07070703, 16'd0,    1'b1, 2'd0, 1'b0}, // R5 shallowest
    '{1'b0, 4'd0, 4'hF, 32'h07070703, 16'd0,    1'b0, 2'd0, 1'b0}, // R10 idle
    '{1'b1, 4'd0, 4'hF, 32'h05050505, 16'd0,    1'b1, 2'd1, 1'b0}, // R6 tie after p0
    '{1'b1, 4'd0, 4'hF, 32'h05050505, 16'd0,    1'b1, 2'd2, 1'b0}, // R6/R7 p1 bumped
    '{1'b1, 4'd0, 4'hB, 32'h09000909, 16'd0,    1'b1, 2'd3, 1'b0}, // R4 p2 down
    '{1'b1, 4'd0, 4'h0, 32'h01010101, 16'd0,    1'b0, 2'd0, 1'b1}, // R8 none up
    '{1'b1, 4'd3, 4'hF, 32'h02020102, 16'hFFFF, 1'b1, 2'd1, 1'b0}, // R1/R3 max rate
    '{1'b0, 4'd3, 4'hF, 32'h02020102, 16'hFFFF, 1'b0, 2'd0, 1'b0}  // R10 idle
  };

  task automatic check_out(string tag, logic eg, logic [1:0] ep, logic es);
    n_checks++;
    if (grant_valid !== eg || stall !== es || (eg && grant_plane !== ep)) begin
      n_errors++;
      $display("FAIL %s: actual grant=%0b plane=%0d stall=%0b expected grant=%0b plane=%0d stall=%0b",
               tag, grant_valid, grant_plane, stall, eg, ep, es);
    end
  endtask

  task automatic drive(logic rq, logic [3:0] d, logic [3:0] lk, logic [31:0] q, logic [15:0] th);
    req_valid      = rq;
    req_dest       = d;
    link_up        = lk;
    qdepth         = q;
    rate_threshold = th;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    rate_wr_en = 1'b0;
    #7;
    @(negedge clk);
    check_out("R1 idle in reset", 1'b0, 2'd0, 1'b0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rate_wr_dest = '0;
    rate_wr_plane = '0;
    rate_wr_data = '0;
    drive(1'b0, 4'd0, 4'hF, 32'h0, 16'd0);
    do_reset();

    foreach (VECS[i]) begin
      drive(VECS[i].req, VECS[i].dest, VECS[i].link, VECS[i].q, VECS[i].thr);
      @(negedge clk);
      check_out($sformatf("vector %0d", i), VECS[i].exp_g, VECS[i].exp_p, VECS[i].exp_s);
      next_cycle();
    end
    // state now: last granted plane 1, no bump

    // R9: write and request in the same cycle -> stall
    rate_wr_en = 1'b1; rate_wr_dest = 4'd5; rate_wr_plane = 2'd0; rate_wr_data = 16'd100;
    drive(1'b1, 4'd5, 4'hF, 32'h05050500, 16'd0);
    @(negedge clk);
    check_out("R9 write priority", 1'b0, 2'd0, 1'b1);
    next_cycle();
    rate_wr_en = 1'b0;

    // R2/R3: p0 rate 100 < 200 excluded; tie at 5 from p2
    drive(1'b1, 4'd5, 4'hF, 32'h05050500, 16'd200);
    @(negedge clk);
    check_out("R2 R3 below threshold", 1'b1, 2'd2, 1'b0);
    next_cycle();

    // R11: other destination unaffected, p0 shallowest
    drive(1'b1, 4'd6, 4'hF, 32'h05050500, 16'd200);
    @(negedge clk);
    check_out("R11 other dest", 1'b1, 2'd0, 1'b0);
    next_cycle();

    // R3: rate equal to threshold is eligible (p0 eff 1 still lowest)
    drive(1'b1, 4'd5, 4'hF, 32'h05050500, 16'd100);
    @(negedge clk);
    check_out("R3 equal threshold", 1'b1, 2'd0, 1'b0);
    next_cycle();

    // R7: p0 bumped 4->5 ties p1; round robin after p0 picks p1
    drive(1'b1, 4'd0, 4'hF, 32'h14140504, 16'd0);
    @(negedge clk);
    check_out("R7 back-to-back bump", 1'b1, 2'd1, 1'b0);
    next_cycle();
    drive(1'b1, 4'd0, 4'hF, 32'h14140504, 16'd0);
    @(negedge clk);
    check_out("R7 bump on p1 only", 1'b1, 2'd0, 1'b0);
    next_cycle();

    // R8: held request stalls, then granted when a plane comes up
    drive(1'b1, 4'd0, 4'h0, 32'h03030303, 16'd0);
    @(negedge clk);
    check_out("R8 stall", 1'b0, 2'd0, 1'b1);
    next_cycle();
    drive(1'b1, 4'd0, 4'h4, 32'h03030303, 16'd0);
    @(negedge clk);
    check_out("R8 resume", 1'b1, 2'd2, 1'b0);
    next_cycle();

    // R4: p0 shallowest but down; p2 bumped; p3 first after p2
    drive(1'b1, 4'd0, 4'hE, 32'h03030300, 16'd0);
    @(negedge clk);
    check_out("R4 link down", 1'b1, 2'd3, 1'b0);
    next_cycle();

    // R1: after reset, first tie goes to plane 0
    do_reset();
    drive(1'b1, 4'd0, 4'hF, 32'h01010101, 16'hFFFF);
    @(negedge clk);
    check_out("R1 first tie", 1'b1, 2'd0, 1'b0);
    next_cycle();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule